// File: doc/BRIEF.md
# Rank-Select of Zero Bits

This block finds where the n-th clear bit of a data word sits. Ranks count from the least significant end and start at zero, so rank 0 picks the lowest clear bit, rank 1 the next one up, and so on. The block returns the bit position together with a hit flag. The flag is low when the word holds no clear bit of the requested rank.

Internally the word is complemented, so the search looks for set bits. A population-count tree forms one-counts over fields of 1, 2, 4, 8 and 16 bits and the whole word. A binary descent then walks from the widest half-field down to single bits. At each level it compares the remaining rank against the count of the lower half at the current offset. When the rank is at least that count, it moves the offset up by the half width and subtracts the count. A parameter places the result either directly on the outputs or in an output register that adds one cycle of latency and carries a valid strobe.

Top module: `nz_select`

## Requirements
- R1: Rank 0 returns the position of the least significant clear bit of the word, with the hit flag high.
- R2: For every word and every rank below the word's number of clear bits, the index is the position of the clear bit that has exactly `rank` clear bits below it, and the hit flag is high.
- R3: When the rank is greater than or equal to the number of clear bits in the word, the hit flag is low and the index reads 0.
- R4: A word with every bit set gives a low hit flag for every rank from 0 to 32.
- R5: A word with every bit clear returns index equal to the rank for ranks 0 to 31 with hit high, and a miss for rank 32.
- R6: For the word 0xFFFFFE6D, ranks 0, 1, 2 and 3 return indices 1, 4, 7 and 8, and rank 4 misses.
- R7: In registered mode, the result for inputs presented with `in_vld` high appears one clock later, with `out_vld` high in that cycle. `out_vld` is low in any cycle that follows a cycle with `in_vld` low.
- R8: In registered mode, a cycle with `in_vld` low leaves `idx_o` and `hit_o` unchanged, whatever is on `word_i` and `rank_i`.
- R9: In registered mode, a synchronous active-high reset clears `out_vld`, `hit_o` and `idx_o` to 0 at the next clock edge.
- R10: In combinational mode, `out_vld` equals `in_vld`, and `idx_o` and `hit_o` follow the inputs in the same cycle without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register and the assertions |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Marks the word and rank as a request |
| word_i | input | WORD_W (32) | Word to search for clear bits |
| rank_i | input | $clog2(WORD_W)+1 (6) | Zero-based rank of the clear bit wanted |
| out_vld | output | 1 | Marks the result as valid |
| idx_o | output | $clog2(WORD_W) (5) | Bit position of the selected clear bit; 0 on a miss |
| hit_o | output | 1 | High when the requested clear bit exists |

## Verification
The bench builds two copies of the block at the default 32-bit width: one with `MODE = NZ_REGISTERED` and one with `MODE = NZ_COMBINATIONAL`, and drives both from the same inputs. The registered copy exposes the one-cycle latency, holding while `in_vld` is low, and reset clearing. The combinational copy shows that the results settle within the same cycle and that `out_vld` passes straight through. Both copies are checked against a bit-by-bit counting loop for every rank from 0 to 32. The words include random and sparse values, the all-clear and all-set words, and the ten-bit example pattern.

// File: rtl/nz_pkg.sv
package nz_pkg;

    typedef enum logic {
        NZ_COMBINATIONAL = 1'b0,
        NZ_REGISTERED    = 1'b1
    } nz_mode_e;

    // Bit offset of tree level l inside the flat count vector.
    // Level l holds (w >> l) fields of cw bits each; the levels are stacked
    // from level 0 upward, so the sum of the lower levels is 2w - 2(w >> l).
    function automatic int nz_lvl_base(input int l, input int w, input int cw);
        return cw * (2 * w - 2 * (w >> l));
    endfunction

endpackage

// File: rtl/nz_count_tree.sv
module nz_count_tree #(
    parameter int WORD_W = 32,
    parameter int LVLS   = $clog2(WORD_W),
    parameter int CW     = LVLS + 1,
    localparam int FLAT_W = CW * (2 * WORD_W - 1)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [FLAT_W-1:0] cnt_o
);
    import nz_pkg::*;

    // Level 0: one bit per field, set where the word holds a zero.
    for (genvar f = 0; f < WORD_W; f++) begin : g_leaf
        assign cnt_o[nz_lvl_base(0, WORD_W, CW) + CW*f +: CW] =
            {{(CW-1){1'b0}}, ~word_i[f]};
    end

    // Each higher level adds adjacent pairs of the level below.
    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        localparam int NF   = WORD_W >> l;
        localparam int BASE = nz_lvl_base(l, WORD_W, CW);
        localparam int PREV = nz_lvl_base(l - 1, WORD_W, CW);
        for (genvar f = 0; f < NF; f++) begin : g_fld
            assign cnt_o[BASE + CW*f +: CW] =
                cnt_o[PREV + CW*(2*f) +: CW] + cnt_o[PREV + CW*(2*f+1) +: CW];
        end
    end

endmodule

// File: rtl/nz_descent.sv
module nz_descent #(
    parameter int WORD_W = 32,
    parameter int LVLS   = $clog2(WORD_W),
    parameter int CW     = LVLS + 1,
    localparam int FLAT_W = CW * (2 * WORD_W - 1)
) (
    input  logic [FLAT_W-1:0] cnt_i,
    input  logic [CW-1:0]     rank_i,
    output logic [LVLS-1:0]   idx_o,
    output logic              hit_o
);
    import nz_pkg::*;

    logic [CW-1:0]   total;
    logic [CW-1:0]   rem;
    logic [CW-1:0]   half_cnt;
    logic [LVLS-1:0] pos;

    assign total = cnt_i[nz_lvl_base(LVLS, WORD_W, CW) +: CW];

    always_comb begin
        rem      = rank_i;
        pos      = '0;
        half_cnt = '0;
        for (int k = LVLS - 1; k >= 0; k--) begin
            // Lower half of the (2^(k+1))-bit field that starts at pos.
            half_cnt = cnt_i[nz_lvl_base(k, WORD_W, CW) + CW*int'(pos >> k) +: CW];
            if (rem >= half_cnt) begin
                pos = pos + LVLS'(1 << k);
                rem = rem - half_cnt;
            end
        end
    end

    assign hit_o = (rank_i < total);
    assign idx_o = hit_o ? pos : '0;

endmodule

// File: rtl/nz_select.sv
module nz_select #(
    parameter int               WORD_W = 32,
    parameter nz_pkg::nz_mode_e MODE   = nz_pkg::NZ_REGISTERED,
    localparam int IDX_W  = $clog2(WORD_W),
    localparam int RANK_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] word_i,
    input  logic [RANK_W-1:0] rank_i,
    output logic              out_vld,
    output logic [IDX_W-1:0]  idx_o,
    output logic              hit_o
);
    import nz_pkg::*;

    localparam int FLAT_W = RANK_W * (2 * WORD_W - 1);

    logic [FLAT_W-1:0] cnt_flat;
    logic [IDX_W-1:0]  idx_c;
    logic              hit_c;

    nz_count_tree #(.WORD_W(WORD_W), .LVLS(IDX_W), .CW(RANK_W)) u_tree (
        .word_i (word_i),
        .cnt_o  (cnt_flat)
    );

    nz_descent #(.WORD_W(WORD_W), .LVLS(IDX_W), .CW(RANK_W)) u_desc (
        .cnt_i  (cnt_flat),
        .rank_i (rank_i),
        .idx_o  (idx_c),
        .hit_o  (hit_c)
    );

    // The selected bit must be a zero of the word.
    AST_HIT_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        hit_c |-> (word_i[idx_c] == 1'b0)) else $error("selected bit is set"); // R2

    AST_ALLSET_MISS: assert property (@(posedge clk) disable iff (rst)
        (&word_i) |-> !hit_c) else $error("hit on all-set word"); // R4

    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (idx_o == '0)) else $error("index not zero on miss"); // R3

    if (MODE == NZ_REGISTERED) begin : g_reg
        typedef struct packed {
            logic             vld;
            logic             hit;
            logic [IDX_W-1:0] idx;
        } stage_t;

        stage_t stage_d, stage_q;

        always_comb begin
            stage_d     = stage_q;
            stage_d.vld = in_vld;
            if (in_vld) begin
                stage_d.hit = hit_c;
                stage_d.idx = idx_c;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= stage_d;
        end

        assign out_vld = stage_q.vld;
        assign hit_o   = stage_q.hit;
        assign idx_o   = stage_q.idx;

        AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> out_vld) else $error("out_vld missing"); // R7

        AST_VLD_DROPS: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> !out_vld) else $error("out_vld without request"); // R7

        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> ($stable(idx_o) && $stable(hit_o))) else $error("result moved while idle"); // R8
    end else begin : g_comb
        assign out_vld = in_vld;
        assign hit_o   = hit_c;
        assign idx_o   = idx_c;
    end

endmodule

// File: tb/nz_select_test.sv
`timescale 1ns/1ps
module nz_select_test;
    import nz_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] word = '0;
    logic [5:0]  rank = '0;

    logic       r_vld, c_vld, r_hit, c_hit;
    logic [4:0] r_idx, c_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    nz_select #(.WORD_W(32), .MODE(NZ_REGISTERED)) uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .word_i(word), .rank_i(rank),
        .out_vld(r_vld), .idx_o(r_idx), .hit_o(r_hit)
    );

    nz_select #(.WORD_W(32), .MODE(NZ_COMBINATIONAL)) uut_c (
        .clk(clk), .rst(rst), .in_vld(in_vld), .word_i(word), .rank_i(rank),
        .out_vld(c_vld), .idx_o(c_idx), .hit_o(c_hit)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [31:0] w;
        logic [5:0]  n;
        logic [4:0]  idx;
        logic        hit;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{"R6", 32'hFFFFFE6D, 6'd0,  5'd1,  1'b1},
        '{"R6", 32'hFFFFFE6D, 6'd1,  5'd4,  1'b1},
        '{"R6", 32'hFFFFFE6D, 6'd2,  5'd7,  1'b1},
        '{"R6", 32'hFFFFFE6D, 6'd3,  5'd8,  1'b1},
        '{"R6", 32'hFFFFFE6D, 6'd4,  5'd0,  1'b0},
        '{"R1", 32'h7FFFFFFF, 6'd0,  5'd31, 1'b1},
        '{"R1", 32'hFFFFFFFE, 6'd0,  5'd0,  1'b1},
        '{"R3", 32'hFFFFFFFE, 6'd1,  5'd0,  1'b0},
        '{"R1", 32'h0000FFFF, 6'd0,  5'd16, 1'b1},
        '{"R2", 32'h0000FFFF, 6'd15, 5'd31, 1'b1},
        '{"R3", 32'h0000FFFF, 6'd16, 5'd0,  1'b0},
        '{"R2", 32'hAAAAAAAA, 6'd5,  5'd10, 1'b1},
        '{"R2", 32'h55555555, 6'd15, 5'd31, 1'b1},
        '{"R5", 32'h00000000, 6'd31, 5'd31, 1'b1},
        '{"R5", 32'h00000000, 6'd32, 5'd0,  1'b0},
        '{"R4", 32'hFFFFFFFF, 6'd0,  5'd0,  1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference: walk the bits, counting zeros, independent of any tree.
    task automatic ref_sel(input logic [31:0] w, input logic [5:0] n,
                           output logic [4:0] idx, output logic hit);
        int seen = 0;
        idx = '0;
        hit = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (!w[i]) begin
                if (!hit && seen == int'(n)) begin
                    idx = 5'(i);
                    hit = 1'b1;
                end
                seen++;
            end
        end
    endtask

    // Drive one request; check the combinational copy within the cycle and
    // the registered copy one edge later.
    task automatic apply(input string req, input logic [31:0] w, input logic [5:0] n,
                         input logic [4:0] eidx, input logic ehit);
        @(negedge clk);
        word   = w;
        rank   = n;
        in_vld = 1'b1;
        #1;
        check(req, "comb idx", 32'(c_idx), 32'(eidx));
        check(req, "comb hit", 32'(c_hit), 32'(ehit));
        check("R10", "comb out_vld", 32'(c_vld), 32'd1);
        @(posedge clk);
        #1;
        check(req, "reg idx", 32'(r_idx), 32'(eidx));
        check(req, "reg hit", 32'(r_hit), 32'(ehit));
        check("R7", "reg out_vld", 32'(r_vld), 32'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0]  eidx;
        logic        ehit;
        logic [31:0] w;

        // Reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset out_vld", 32'(r_vld), 32'd0);
        check("R9", "reset hit", 32'(r_hit), 32'd0);
        check("R9", "reset idx", 32'(r_idx), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Table of directed vectors
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("%s", VECS[v].tag);
            apply(tag, VECS[v].w, VECS[v].n, VECS[v].idx, VECS[v].hit);
        end

        // All-clear word, every rank: R5
        for (int n = 0; n <= 32; n++)
            apply("R5", 32'h0, 6'(n), (n < 32) ? 5'(n) : 5'd0, n < 32);

        // All-set word, every rank: R4
        for (int n = 0; n <= 32; n++)
            apply("R4", 32'hFFFFFFFF, 6'(n), 5'd0, 1'b0);

        // Random and sparse words against the reference loop: R2 and R3
        for (int t = 0; t < 120; t++) begin
            case (t % 3)
                0:       w = $urandom;
                1:       w = $urandom | $urandom;
                default: w = $urandom & $urandom;
            endcase
            for (int n = 0; n <= 32; n++) begin
                ref_sel(w, 6'(n), eidx, ehit);
                apply(ehit ? "R2" : "R3", w, 6'(n), eidx, ehit);
            end
        end

        // Hold while idle: R8, with comb copy following at once: R10
        apply("R6", 32'hFFFFFE6D, 6'd2, 5'd7, 1'b1);
        @(negedge clk);
        in_vld = 1'b0;
        word   = 32'h0;
        rank   = 6'd20;
        #1;
        check("R10", "comb out_vld idle", 32'(c_vld), 32'd0);
        check("R10", "comb idx idle", 32'(c_idx), 32'd20);
        @(posedge clk);
        #1;
        check("R8", "reg idx held", 32'(r_idx), 32'd7);
        check("R8", "reg hit held", 32'(r_hit), 32'd1);
        check("R7", "reg out_vld idle", 32'(r_vld), 32'd0);
        @(posedge clk);
        #1;
        check("R8", "reg idx still held", 32'(r_idx), 32'd7);

        // Reset in mid-run: R9
        apply("R2", 32'h0000FFFF, 6'd3, 5'd19, 1'b1);
        @(negedge clk);
        rst    = 1'b1;
        in_vld = 1'b1;
        @(posedge clk);
        #1;
        check("R9", "mid reset out_vld", 32'(r_vld), 32'd0);
        check("R9", "mid reset hit", 32'(r_hit), 32'd0);
        check("R9", "mid reset idx", 32'(r_idx), 32'd0);
        @(negedge clk);
        rst    = 1'b0;
        in_vld = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule